// File: doc/BRIEF.md
# Programmable Soft-Start Ramp Generator

This block paces the digital reference code of one regulator channel during turn-on. While the channel's internal enable is high, it moves its output code from zero toward the channel's target code one count at a time. A prescaled timebase sets the pace. When the code reaches the target it stays there and a done flag goes high. If the target code changes later, the output follows it up or down at the same paced rate, one count per interval.

The ramp time is chosen by a 4-bit setting that is written through a simple write strobe. Setting N gives a full-scale ramp of (N+1) base units, so the sixteen settings cover equal increments from one to sixteen units. The step interval is (N+1) × STEP_TICKS prescaler ticks. A prescaler tick lasts PRESC_DIV clocks, and one base unit is (2^CODE_W − 1) × STEP_TICKS × PRESC_DIV clocks. Any ramp to a target below full scale therefore ends within the selected time. The setting resets to 0 (one unit) for a switching channel and to 2 (three units) for a linear-regulator channel; the IS_LDO parameter picks which.

When the enable drops, the ramp stops. The code is forced to zero on the next clock, and a discharge request is held until the channel is enabled again. The output is never ramped down.

Top module: `softstart_ramp`

## Requirements
- R1: After reset, ref_code is 0, ramp_done is 0 and discharge_req is 1.
- R2: While ch_en stays high, ref_code changes by exactly one count per step. Each step lands (N+1) × STEP_TICKS × PRESC_DIV clocks after the previous one. The first step lands that many clock edges after the first edge at which ch_en is sampled high. N is the current 4-bit setting.
- R3: A ramp never passes target_code. Once the code equals the target, it holds while the target is unchanged.
- R4: ramp_done is 1 exactly when ch_en is high and ref_code equals target_code.
- R5: At the first clock edge at which ch_en is sampled low, ref_code goes to 0 and discharge_req goes to 1. discharge_req goes to 0 at the first edge at which ch_en is sampled high.
- R6: If ch_en is sampled low at the same edge at which a step is due, the disable wins and ref_code becomes 0, not the stepped value.
- R7: A write with ss_we high loads ss_wdata into the 4-bit setting at that edge. All sixteen values 0..15 give the interval stated in R2.
- R8: The setting resets to 0 when IS_LDO is 0 and to 2 when IS_LDO is 1.
- R9: If target_code changes while enabled, ref_code moves toward the new target by +1 or −1 per paced step, as needed, until it is equal to the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Internal channel enable |
| target_code | input | CODE_W | Target reference code chosen by the voltage select |
| ss_we | input | 1 | Write strobe for the soft-start setting |
| ss_wdata | input | 4 | Soft-start setting value to write |
| ref_code | output | CODE_W | Paced reference code sent to the DAC |
| ramp_done | output | 1 | High while enabled and ref_code equals target_code |
| discharge_req | output | 1 | Active discharge request, high while the channel is off |

## Verification
A disable and a due step can fall on the same clock edge. The bench provokes this by enabling the channel with the shortest setting and waiting for the first step. It then drops ch_en on the negative edge just before the next step is due, and expects ref_code to be 0 rather than 2 after that edge, with discharge_req high. A second coincidence is also checked: a target change arriving while the code already sits at the old target. There the bench allows the first move to come at any point within one interval, and then requires every later step to land exactly one interval apart.

// File: rtl/ss_ramp_pkg.sv
package ss_ramp_pkg;
   localparam int SS_SET_W = 4;
   localparam int SS_NUM_SETTINGS = 1 << SS_SET_W;

   function automatic logic [SS_SET_W-1:0] ss_reset_setting(input bit is_ldo);
      return is_ldo ? SS_SET_W'(2) : SS_SET_W'(0);
   endfunction
endpackage

// File: rtl/ss_tick_div.sv
module ss_tick_div #(
   parameter int PRESC_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (PRESC_DIV < 1) begin : g_bad
         $error("PRESC_DIV must be at least 1");
      end else if (PRESC_DIV == 1) begin : g_pass
         assign tick = run;
      end else begin : g_cnt
         localparam int PW = $clog2(PRESC_DIV);
         localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);
         logic [PW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (!run)       cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                 cnt <= cnt + PW'(1);
         end

         assign tick = run && (cnt == LAST);

         a_r2_presc_bound: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= LAST);
      end
   endgenerate
endmodule

// File: rtl/ss_step_pacer.sv
module ss_step_pacer
   import ss_ramp_pkg::*;
#(
   parameter int STEP_TICKS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                tick,
   input  logic [SS_SET_W-1:0] setting,
   output logic                step
);
   localparam int IV_W = $clog2(SS_NUM_SETTINGS * STEP_TICKS) + 1;

   generate
      if (STEP_TICKS < 1) begin : g_bad
         $error("STEP_TICKS must be at least 1");
      end
   endgenerate

   logic [IV_W-1:0] interval;
   logic [IV_W-1:0] cnt;

   always_comb begin
      interval = (IV_W'(setting) + IV_W'(1)) * IV_W'(STEP_TICKS);
   end

   assign step = tick && (cnt >= interval - IV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (!run)  cnt <= '0;
      else if (tick)  cnt <= step ? '0 : cnt + IV_W'(1);
   end

   a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (tick && run));
   a_r5_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run) |-> (cnt == '0));
endmodule

// File: rtl/softstart_ramp.sv
module softstart_ramp
   import ss_ramp_pkg::*;
#(
   parameter int CODE_W     = 6,
   parameter int PRESC_DIV  = 40,
   parameter int STEP_TICKS = 8,
   parameter bit IS_LDO     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ch_en,
   input  logic [CODE_W-1:0] target_code,
   input  logic              ss_we,
   input  logic [3:0]        ss_wdata,
   output logic [CODE_W-1:0] ref_code,
   output logic              ramp_done,
   output logic              discharge_req
);
   localparam logic [SS_SET_W-1:0] RST_SET = ss_reset_setting(IS_LDO);

   generate
      if (CODE_W < 1) begin : g_bad_w
         $error("CODE_W must be at least 1");
      end
   endgenerate

   logic [SS_SET_W-1:0] setting_q;
   logic [CODE_W-1:0]   code_q;
   logic                dis_q;
   logic                tick;
   logic                step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     setting_q <= RST_SET;
      else if (ss_we) setting_q <= ss_wdata;
   end

   ss_tick_div #(.PRESC_DIV(PRESC_DIV)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ch_en),
      .tick (tick)
   );

   ss_step_pacer #(.STEP_TICKS(STEP_TICKS)) u_pace (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ch_en),
      .tick   (tick),
      .setting(setting_q),
      .step   (step)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             code_q <= '0;
      else if (!ch_en)                        code_q <= '0;
      else if (step && (code_q < target_code)) code_q <= code_q + CODE_W'(1);
      else if (step && (code_q > target_code)) code_q <= code_q - CODE_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dis_q <= 1'b1;
      else        dis_q <= !ch_en;
   end

   assign ref_code      = code_q;
   assign ramp_done     = ch_en && (code_q == target_code);
   assign discharge_req = dis_q;

   a_r2_single_count: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ch_en) |-> ($stable(code_q) || (code_q == $past(code_q) + CODE_W'(1))
                        || (code_q == $past(code_q) - CODE_W'(1))));
   a_r3_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(code_q) <= $past(target_code)) |-> (code_q <= $past(target_code)));
   a_r4_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ramp_done) |-> $stable(code_q));
   a_r5_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ch_en) |-> (code_q == '0 && discharge_req));
   a_r5_on_no_dis: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ch_en) |-> !discharge_req);
endmodule

// File: tb/sim_softstart_ramp.sv
module sim_softstart_ramp;
   localparam int CW = 4;
   localparam int PD = 2;
   localparam int ST = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n, en0, en1, we;
   logic [CW-1:0] tgt, tgt1;
   logic [3:0]    wd;
   logic [CW-1:0] code0, code1;
   logic          done0, dis0, done1, dis1;

   int checks = 0;
   int fails  = 0;

   softstart_ramp #(.CODE_W(CW), .PRESC_DIV(PD), .STEP_TICKS(ST), .IS_LDO(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .ch_en(en0), .target_code(tgt), .ss_we(we),
      .ss_wdata(wd), .ref_code(code0), .ramp_done(done0), .discharge_req(dis0));

   softstart_ramp #(.CODE_W(CW), .PRESC_DIV(PD), .STEP_TICKS(ST), .IS_LDO(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .ch_en(en1), .target_code(tgt1), .ss_we(1'b0),
      .ss_wdata(4'd0), .ref_code(code1), .ramp_done(done1), .discharge_req(dis1));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic edges_to_change0(output int n);
      logic [CW-1:0] prev;
      prev = code0;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (code0 == prev && n < 5000);
   endtask

   task automatic set_speed(input int s);
      we = 1'b1;
      wd = 4'(s);
      @(negedge clk);
      we = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n, iv;
      rst_n = 1'b0; en0 = 1'b0; en1 = 1'b0; we = 1'b0; wd = '0;
      tgt = '0; tgt1 = 4'd15;
      cycles(3);
      chk(code0 == 0, "R1 code", int'(code0), 0);
      chk(done0 == 0, "R1 done", int'(done0), 0);
      chk(dis0 == 1, "R1 discharge", int'(dis0), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: default settings, measured as the first step delay
      tgt = 4'd15;
      en0 = 1'b1; en1 = 1'b1;
      edges_to_change0(n);
      chk(n == 1 * ST * PD, "R8 switching default", n, ST * PD);
      begin
         int m;
         m = n;
         while (code1 == 0 && m < 5000) begin
            @(negedge clk);
            m++;
         end
         chk(m == 3 * ST * PD, "R8 ldo default", m, 3 * ST * PD);
      end
      en0 = 1'b0; en1 = 1'b0;
      @(negedge clk);
      chk(code0 == 0 && dis0 == 1, "R5 off", int'(code0), 0);

      // R2/R3/R4/R7: sweep all settings, full-scale ramp
      for (int s = 0; s < 16; s++) begin
         set_speed(s);
         iv = (s + 1) * ST * PD;
         tgt = 4'd15;
         en0 = 1'b1;
         @(negedge clk);
         chk(dis0 == 0, "R5 discharge released", int'(dis0), 0);
         chk(done0 == 0, "R4 not done at start", int'(done0), 0);
         n = 1;
         while (code0 == 0 && n < 5000) begin
            @(negedge clk);
            n++;
         end
         chk(n == iv, "R7 first step delay", n, iv);
         for (int k = 2; k <= 15; k++) begin
            edges_to_change0(n);
            chk(n == iv, "R2 step spacing", n, iv);
            chk(int'(code0) == k, "R2 step value", int'(code0), k);
         end
         chk(done0 == 1, "R4 done at target", int'(done0), 1);
         cycles(2 * iv);
         chk(code0 == 15, "R3 hold at target", int'(code0), 15);
         en0 = 1'b0;
         @(negedge clk);
         chk(code0 == 0, "R5 zero on disable", int'(code0), 0);
         chk(done0 == 0, "R4 done cleared", int'(done0), 0);
         chk(dis0 == 1, "R5 discharge on disable", int'(dis0), 1);
      end

      // R3: low target stops there
      set_speed(1);
      iv = 2 * ST * PD;
      tgt = 4'd5;
      en0 = 1'b1;
      cycles(5 * iv);
      chk(code0 == 5 && done0 == 1, "R3 stop at low target", int'(code0), 5);
      cycles(3 * iv);
      chk(code0 == 5, "R3 no overshoot", int'(code0), 5);

      // R9: target moves up then down after done
      tgt = 4'd9;
      @(negedge clk);
      chk(done0 == 0, "R4 done drops on target change", int'(done0), 0);
      edges_to_change0(n);
      chk(n < iv && code0 == 6, "R9 first upward move", int'(code0), 6);
      for (int k = 7; k <= 9; k++) begin
         edges_to_change0(n);
         chk(n == iv && int'(code0) == k, "R9 upward step", int'(code0), k);
      end
      cycles(2 * iv);
      chk(code0 == 9 && done0 == 1, "R9 settle high", int'(code0), 9);
      tgt = 4'd3;
      edges_to_change0(n);
      chk(code0 == 8, "R9 first downward move", int'(code0), 8);
      for (int k = 7; k >= 3; k--) begin
         edges_to_change0(n);
         chk(n == iv && int'(code0) == k, "R9 downward step", int'(code0), k);
      end
      cycles(2 * iv);
      chk(code0 == 3 && done0 == 1, "R9 settle low", int'(code0), 3);
      en0 = 1'b0;
      @(negedge clk);

      // R6: disable lands on the edge where the second step is due
      set_speed(0);
      iv = ST * PD;
      tgt = 4'd15;
      en0 = 1'b1;
      cycles(iv);
      chk(code0 == 1, "R6 first step", int'(code0), 1);
      cycles(iv - 1);
      en0 = 1'b0;
      @(negedge clk);
      chk(code0 == 0, "R6 disable beats step", int'(code0), 0);
      chk(dis0 == 1, "R6 discharge", int'(dis0), 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule